// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins (eight by default) and turns their activity into one interrupt request toward a CPU. Each pin is first brought into the clock domain by a two-stage synchroniser. A two-bit sense code per line then selects what counts as an event on that line: a low level, any change, a falling edge or a rising edge. For the three edge codes an event latches a per-line flag. For the level code no flag is ever kept, and the request follows the synchronised pin directly. The pin is only ever sampled and never driven by this block, so a pin that the chip itself drives as an output still triggers its own line.

Software reaches the block over a small register bus. The bus has a per-line enable mask, the flag vector with write-one-to-clear behaviour, and the sense codes packed four lines to a byte. A line is pending when its enable bit and the global interrupt enable input are both set and either its flag is set (edge codes) or its synchronised pin is low (level code). A small arbiter state machine presents the lowest-numbered pending line on `irq_idx` together with `irq_req`. When the CPU pulses `irq_ack`, the flag of the presented line is cleared.

The arbiter has three states. ARB_IDLE means nothing is requested; it moves to ARB_REQ as soon as any line is pending and latches the winning index. ARB_REQ drives the request and holds the index. It moves to ARB_RETIRE on an acknowledge, or back to ARB_IDLE if the presented line stops pending without one (flag cleared by software, enable or global enable dropped). ARB_RETIRE lasts one cycle with the request low, so the cleared flag settles, and then always returns to ARB_IDLE.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the enable register (address 0), the flag register (address 1), both sense registers (addresses 2 and 3) and `irq_req` all read zero.
- R2: With sense code 11 (rising), a low-to-high change on a pin sets that line's flag within three clock cycles, and a high-to-low change does not.
- R3: With sense code 10 (falling), a high-to-low change sets the flag, and a low-to-high change does not.
- R4: With sense code 01 (any change), both a rising and a falling change set the flag, and a steady pin does not.
- R5: With sense code 00 (low level), the line's flag bit always reads zero. The line requests while its synchronised pin is low and stops requesting once the pin is high again.
- R6: Writing address 1 clears every flag whose data bit is one; data bits that are zero leave their flags unchanged.
- R7: A flag latches whether or not the line is enabled, but `irq_req` is raised only when the line's enable bit and `gie` are both one; with `gie` low, `irq_req` is low one cycle later.
- R8: When several lines are pending, `irq_idx` shows the lowest-numbered one, and `irq_req` rises the cycle after a line becomes pending in ARB_IDLE.
- R9: An `irq_ack` while `irq_req` is high clears the flag of the line on `irq_idx` and drops `irq_req` for the next cycle. While requesting without an acknowledge, `irq_idx` stays stable.
- R10: The enable register and the sense registers read back what was written. Line i's sense code sits at bits 2*(i mod 4)+1 : 2*(i mod 4) of address 2 + i/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | N_LINES | Raw external interrupt pins |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request toward the CPU |
| irq_idx | output | IDX_W | Index of the requesting line |
| irq_ack | input | 1 | Vector taken; clears the presented line's flag |

## Verification
The assertions take for granted that `irq_ack` only arrives while `irq_req` is high and lasts one cycle. They also take for granted that pins stay steady long enough to pass both synchroniser stages, so every edge is seen as exactly one change of the synchronised value. The stimulus drives pins, acknowledges and bus writes on the falling clock edge. It holds each pin level for several cycles and pulses `irq_ack` only after it has seen the request high. Register writes never coincide with a pin change on the same line, so the set-over-clear ordering is never exercised by accident.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'b00,
        ARB_REQ    = 2'b01,
        ARB_RETIRE = 2'b10
    } arb_state_e;

    localparam int ADDR_EN     = 0;
    localparam int ADDR_FLAG   = 1;
    localparam int ADDR_SENSE0 = 2;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic [1:0] sense,
    input  logic       clr,
    output logic       flag_o,
    output logic       lvl_o
);
    sense_e mode;
    logic   prev_q;
    logic   flag_q;
    logic   rise;
    logic   fall;
    logic   hit;

    assign mode = sense_e'(sense);
    assign rise = pin_s & ~prev_q;
    assign fall = ~pin_s & prev_q;

    always_comb begin
        unique case (mode)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = rise | fall;
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            default:    hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (mode == SENSE_LOW) flag_q <= 1'b0;
            else if (hit)          flag_q <= 1'b1;
            else if (clr)          flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign lvl_o  = (mode == SENSE_LOW) & ~pin_s;

    // R5
    level_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW) |=> !flag_q);
    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr && mode != SENSE_LOW) |=> flag_q);
    // R2
    edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
endmodule

// File: rtl/extint_arb.sv
module extint_arb
    import extint_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pend,
    input  logic               ack,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    output logic [N_LINES-1:0] ack_clr
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] win;

    always_comb begin
        win = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend[i]) win = IDX_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|pend) begin
                    state_d = ARB_REQ;
                    idx_d   = win;
                end
            end
            ARB_REQ: begin
                if (ack)               state_d = ARB_RETIRE;
                else if (!pend[idx_q]) state_d = ARB_IDLE;
            end
            ARB_RETIRE: state_d = ARB_IDLE;
            default:    state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        irq_req = (state_q == ARB_REQ);
        irq_idx = idx_q;
        ack_clr = '0;
        if (state_q == ARB_REQ && ack) ack_clr[idx_q] = 1'b1;
    end

    // R9
    ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);
    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> (!irq_req || $stable(irq_idx)));
    // R8
    req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && |pend) |=> irq_req);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int N_LINES   = 8,
    parameter int DATA_W    = 8,
    localparam int LPR      = DATA_W / 2,
    localparam int SENSE_RG = (N_LINES + LPR - 1) / LPR,
    localparam int ADDR_W   = $clog2(ADDR_SENSE0 + SENSE_RG),
    localparam int IDX_W    = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] ext_pin,
    input  logic               gie,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    input  logic               irq_ack
);
    logic [N_LINES-1:0]      pin_s;
    logic [N_LINES-1:0]      en_q;
    logic [N_LINES-1:0][1:0] sense_q;
    logic [N_LINES-1:0]      flag;
    logic [N_LINES-1:0]      lvl;
    logic [N_LINES-1:0]      clr;
    logic [N_LINES-1:0]      ack_clr;
    logic [N_LINES-1:0]      pend;
    logic                    wr_en, wr_flag;

    assign wr_en   = reg_wr && (reg_addr == ADDR_W'(ADDR_EN));
    assign wr_flag = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAG));

    extint_sync #(.WIDTH(N_LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (ext_pin),
        .d_out(pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            sense_q <= '0;
        end else begin
            if (wr_en) en_q <= reg_wdata[N_LINES-1:0];
            for (int i = 0; i < N_LINES; i++) begin
                if (reg_wr && reg_addr == ADDR_W'(ADDR_SENSE0 + i / LPR))
                    sense_q[i] <= reg_wdata[(i % LPR) * 2 +: 2];
            end
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign clr[g] = (wr_flag && reg_wdata[g]) || ack_clr[g];
        extint_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_s[g]),
            .sense (sense_q[g]),
            .clr   (clr[g]),
            .flag_o(flag[g]),
            .lvl_o (lvl[g])
        );
    end

    assign pend = (flag | lvl) & en_q & {N_LINES{gie}};

    extint_arb #(.N_LINES(N_LINES)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .ack    (irq_ack),
        .irq_req(irq_req),
        .irq_idx(irq_idx),
        .ack_clr(ack_clr)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_EN))   reg_rdata[N_LINES-1:0] = en_q;
        if (reg_addr == ADDR_W'(ADDR_FLAG)) reg_rdata[N_LINES-1:0] = flag;
        for (int i = 0; i < N_LINES; i++) begin
            if (reg_addr == ADDR_W'(ADDR_SENSE0 + i / LPR))
                reg_rdata[(i % LPR) * 2 +: 2] = sense_q[i];
        end
    end

    // R7
    no_req_without_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq_req);
    // R8
    req_has_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && $past(irq_req)) |-> $past(|pend));
endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ext_pin = 8'hFF;
    logic       gie = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    extint_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .gie(gie),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_idx(irq_idx),
        .irq_ack(irq_ack)
    );

    // {sense code, pin before, pin after, expected flag} for line 0
    localparam logic [4:0] VEC [0:9] = '{
        {2'b11, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b1, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b1},
        {2'b01, 1'b1, 1'b1, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'b11: return "R2";
            2'b10: return "R3";
            2'b01: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);

        // R1 reset state
        rd(2'd0, d); check("R1 enable", d, 8'h00);
        rd(2'd1, d); check("R1 flags", d, 8'h00);
        rd(2'd2, d); check("R1 sense0", d, 8'h00);
        rd(2'd3, d); check("R1 sense1", d, 8'h00);
        check("R1 irq_req", irq_req, 1'b0);

        // table of sense modes on line 0
        foreach (VEC[k]) begin
            wr(2'd2, {6'b0, VEC[k][4:3]});
            @(negedge clk); ext_pin[0] = VEC[k][2];
            wait_cyc(5);
            wr(2'd1, 8'hFF);
            @(negedge clk); ext_pin[0] = VEC[k][1];
            wait_cyc(5);
            rd(2'd1, d);
            check(tag_of(VEC[k][4:3]), d[0], VEC[k][0]);
        end
        ext_pin[0] = 1'b1;
        wr(2'd2, 8'h00);
        wait_cyc(4);
        wr(2'd1, 8'hFF);

        // R7 gating, line 2 rising
        wr(2'd2, 8'h30);
        @(negedge clk); ext_pin[2] = 1'b0;
        wait_cyc(4);
        @(negedge clk); ext_pin[2] = 1'b1;
        wait_cyc(5);
        rd(2'd1, d); check("R7 flag latched while disabled", d, 8'h04);
        gie = 1'b1; wait_cyc(4);
        check("R7 enable low no request", irq_req, 1'b0);
        gie = 1'b0; wr(2'd0, 8'h04); wait_cyc(4);
        check("R7 gie low no request", irq_req, 1'b0);
        gie = 1'b1; wait_cyc(4);
        check("R7 request raised", irq_req, 1'b1);
        check("R7 index", irq_idx, 3'd2);

        // R6 write-one-clear
        wr(2'd1, 8'h00); wait_cyc(2);
        rd(2'd1, d); check("R6 zero write keeps flag", d, 8'h04);
        wr(2'd1, 8'h04); wait_cyc(3);
        rd(2'd1, d); check("R6 one write clears flag", d, 8'h00);
        check("R6 request gone", irq_req, 1'b0);

        // R8 priority and R9 acknowledge
        wr(2'd2, 8'hF0);
        wr(2'd3, 8'h0C);
        wr(2'd0, 8'h28);
        @(negedge clk); ext_pin[3] = 1'b0; ext_pin[5] = 1'b0;
        wait_cyc(4);
        @(negedge clk); ext_pin[3] = 1'b1; ext_pin[5] = 1'b1;
        wait_cyc(6);
        check("R8 request", irq_req, 1'b1);
        check("R8 lowest index wins", irq_idx, 3'd3);
        ack_pulse();
        check("R9 request drops after ack", irq_req, 1'b0);
        rd(2'd1, d); check("R9 ack clears presented flag", d, 8'h20);
        wait_cyc(3);
        check("R8 next line requests", irq_req, 1'b1);
        check("R8 next index", irq_idx, 3'd5);
        ack_pulse();
        wait_cyc(2);
        rd(2'd1, d); check("R9 second ack clears", d, 8'h00);
        check("R9 idle after acks", irq_req, 1'b0);

        // R5 level line 6
        wr(2'd0, 8'h40);
        @(negedge clk); ext_pin[6] = 1'b0;
        wait_cyc(4);
        check("R5 level request", irq_req, 1'b1);
        check("R5 level index", irq_idx, 3'd6);
        rd(2'd1, d); check("R5 level flag reads zero", d, 8'h00);
        @(negedge clk); ext_pin[6] = 1'b1;
        wait_cyc(4);
        check("R5 level release", irq_req, 1'b0);

        // R10 readback
        gie = 1'b0;
        wr(2'd0, 8'hA5); rd(2'd0, d); check("R10 enable readback", d, 8'hA5);
        wr(2'd3, 8'h9C); rd(2'd3, d); check("R10 sense1 readback", d, 8'h9C);
        rd(2'd2, d); check("R10 sense0 readback", d, 8'hF0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule